// File: doc/BRIEF.md
# ECC Page Result Evaluator

This block sits after the hardware error-correction stage of a flash page reader. For each page read it takes one 16-bit result word. The word gives the corrected-error count of the leading packet of the page, the largest corrected-error count among the remaining packets, and one success bit for each of those two groups. A flag on the same transfer marks pages that were found blank. For each report the block registers a pass/fail verdict and a per-page bitflip figure. It also keeps two saturating running totals: corrected bits and failed pages. The totals are read on plain output pins and zeroed with a clear input.

Reports arrive on a valid/ready stream. The block accepts a report on any cycle in which valid and ready are both high, and it needs no stall for its own processing. Ready drops only while the counter clear is asserted. A sender holding valid during a clear keeps its report until ready returns, so a report is never lost or counted into a total that is being zeroed. Results leave as a single-cycle pulse with no back-pressure. The verdict and the bitflip figure hold their values until the next accepted report.

Top module: `ecc_report_eval`

## Requirements
- R1: `rpt_ready` is 1 whenever `cnt_clear` is 0 and 0 whenever `cnt_clear` is 1; a report is accepted only on a rising clock edge where `rpt_valid` and `rpt_ready` are both 1.
- R2: `res_valid` is 1 for exactly the one cycle following each accepted report and 0 in every other cycle; `res_fail` and `res_flips` keep their values until the next accepted report.
- R3: The report fields are: bits 5:0 the leading-packet corrected count, bits 13:8 the maximum corrected count over the other packets, bit 7 the leading-packet success bit, bit 15 the other-packets success bit; bits 6 and 14 have no effect on any output.
- R4: For a non-blank page, `res_fail` is 1 when bit 7 is 0 or bit 15 is 0, and `res_flips` is then 0.
- R5: For a non-blank page with both success bits 1, `res_fail` is 0 and `res_flips` is the larger of the two counts.
- R6: When `rpt_empty` is 1 on acceptance, the word is ignored: `res_fail` is 0, `res_flips` is 0, and both totals are unchanged.
- R7: On a successful non-blank page, `corr_total` grows by the sum of the two counts.
- R8: On a failed non-blank page, `fail_total` grows by one and `corr_total` is unchanged.
- R9: Both totals stop at their all-ones value instead of wrapping.
- R10: Reset, or `cnt_clear` at a clock edge, sets both totals to 0; reset also sets `res_valid`, `res_fail` and `res_flips` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rpt_valid | input | 1 | Report word and blank flag are valid |
| rpt_ready | output | 1 | Block can accept a report |
| rpt_word | input | 16 | Result word from the correction stage |
| rpt_empty | input | 1 | Page was detected blank |
| cnt_clear | input | 1 | Zero both running totals |
| res_valid | output | 1 | One-cycle pulse: a new verdict is present |
| res_fail | output | 1 | Page could not be corrected |
| res_flips | output | 6 | Per-page bitflip figure |
| corr_total | output | CNT_W (32) | Saturating total of corrected bits |
| fail_total | output | CNT_W (32) | Saturating total of failed pages |

## Verification
All results of a report accepted at clock edge N are registered at that same edge. This covers `res_valid`, `res_fail`, `res_flips` and both totals, so they are due in the cycle after N. A clear at edge N shows as zero totals in that cycle too. `rpt_ready` follows `cnt_clear` combinationally within the same cycle. The bench changes inputs on falling edges. It samples every registered result at the falling edge right after the accepting edge, and samples `rpt_ready` a moment after it drives `cnt_clear`. The bench builds the block with 8-bit totals, so saturation is reached within a few hundred reports.

// File: rtl/eccr_pkg.sv
package eccr_pkg;
  localparam int REPORT_W = 16;
  localparam int FIELD_W  = 6;
  localparam int SUM_W    = FIELD_W + 1;

  localparam int FIRST_CNT_LSB  = 0;
  localparam int REST_CNT_LSB   = 8;
  localparam int FIRST_OK_BIT   = 7;
  localparam int REST_OK_BIT    = 15;

  typedef struct packed {
    logic               ok_first;
    logic               ok_rest;
    logic [FIELD_W-1:0] cnt_first;
    logic [FIELD_W-1:0] cnt_rest;
  } rpt_fields_t;
endpackage

// File: rtl/eccr_decode.sv
module eccr_decode
  import eccr_pkg::*;
(
  input  logic [REPORT_W-1:0] word,
  output logic                fail,
  output logic [FIELD_W-1:0]  max_cnt,
  output logic [SUM_W-1:0]    sum_cnt
);
  rpt_fields_t f;
  logic        unused_spare;

  always_comb begin
    f.cnt_first = word[FIRST_CNT_LSB +: FIELD_W];
    f.cnt_rest  = word[REST_CNT_LSB  +: FIELD_W];
    f.ok_first  = word[FIRST_OK_BIT];
    f.ok_rest   = word[REST_OK_BIT];
  end

  // spare bits carry no meaning
  assign unused_spare = ^{word[FIRST_CNT_LSB+FIELD_W], word[REST_CNT_LSB+FIELD_W]};

  // success is signalled by a 1, so a 0 in either flag is a failure
  assign fail    = ~(f.ok_first & f.ok_rest);
  assign max_cnt = (f.cnt_first >= f.cnt_rest) ? f.cnt_first : f.cnt_rest;
  assign sum_cnt = {1'b0, f.cnt_first} + {1'b0, f.cnt_rest};
endmodule

// File: rtl/eccr_sat_acc.sv
module eccr_sat_acc #(
  parameter int W     = 32,
  parameter int INC_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [INC_W-1:0] inc,
  output logic [W-1:0]     total
);
  localparam int EXT_W = W + 1;

  logic [EXT_W-1:0] wide_sum;
  logic [W-1:0]     next_total;

  assign wide_sum   = {1'b0, total} + {{(EXT_W-INC_W){1'b0}}, inc};
  assign next_total = wide_sum[W] ? {W{1'b1}} : wide_sum[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    total <= '0;
    else if (clr)  total <= '0;
    else if (en)   total <= next_total;
  end
endmodule

// File: rtl/ecc_report_eval.sv
module ecc_report_eval
  import eccr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rpt_valid,
  output logic                rpt_ready,
  input  logic [REPORT_W-1:0] rpt_word,
  input  logic                rpt_empty,
  input  logic                cnt_clear,
  output logic                res_valid,
  output logic                res_fail,
  output logic [FIELD_W-1:0]  res_flips,
  output logic [CNT_W-1:0]    corr_total,
  output logic [CNT_W-1:0]    fail_total
);
  logic               accept;
  logic               dec_fail;
  logic [FIELD_W-1:0] dec_max;
  logic [SUM_W-1:0]   dec_sum;
  logic               page_good;
  logic               page_bad;

  // clear owns the cycle: reports wait so none lands in a zeroed total
  assign rpt_ready = ~cnt_clear;
  assign accept    = rpt_valid & rpt_ready;

  eccr_decode u_decode (
    .word    (rpt_word),
    .fail    (dec_fail),
    .max_cnt (dec_max),
    .sum_cnt (dec_sum)
  );

  assign page_good = accept & ~rpt_empty & ~dec_fail;
  assign page_bad  = accept & ~rpt_empty &  dec_fail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_fail  <= 1'b0;
      res_flips <= '0;
    end else begin
      res_valid <= accept;
      if (accept) begin
        res_fail  <= page_bad;
        res_flips <= page_good ? dec_max : '0;
      end
    end
  end

  eccr_sat_acc #(.W(CNT_W), .INC_W(SUM_W)) u_corr_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clear),
    .en    (page_good),
    .inc   (dec_sum),
    .total (corr_total)
  );

  eccr_sat_acc #(.W(CNT_W), .INC_W(1)) u_fail_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clear),
    .en    (page_bad),
    .inc   (1'b1),
    .total (fail_total)
  );
endmodule

// File: rtl/eccr_checker.sv
module eccr_checker
  import eccr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rpt_valid,
  input logic                rpt_ready,
  input logic [REPORT_W-1:0] rpt_word,
  input logic                rpt_empty,
  input logic                cnt_clear,
  input logic                res_valid,
  input logic                res_fail,
  input logic [FIELD_W-1:0]  res_flips,
  input logic [CNT_W-1:0]    corr_total,
  input logic [CNT_W-1:0]    fail_total
);
  logic acc;
  assign acc = rpt_valid & rpt_ready;

  AST_READY_VS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_ready == !cnt_clear); // R1
  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> res_valid); // R2
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !res_valid); // R2
  AST_FAIL_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !rpt_empty && !(rpt_word[7] && rpt_word[15])) |=> res_fail && res_flips == '0); // R4
  AST_BLANK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && rpt_empty && !cnt_clear) |=> !res_fail && res_flips == '0
      && $stable(corr_total) && $stable(fail_total)); // R6
  AST_CORR_HOLD_ON_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && res_fail == res_fail && !rpt_empty && !(rpt_word[7] && rpt_word[15]))
      |=> $stable(corr_total)); // R8
  AST_FAIL_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clear |=> fail_total >= $past(fail_total)); // R9
  AST_CORR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clear |=> corr_total >= $past(corr_total)); // R9
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |=> corr_total == '0 && fail_total == '0); // R10
endmodule

bind ecc_report_eval eccr_checker #(.CNT_W(CNT_W)) u_eccr_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .rpt_valid  (rpt_valid),
  .rpt_ready  (rpt_ready),
  .rpt_word   (rpt_word),
  .rpt_empty  (rpt_empty),
  .cnt_clear  (cnt_clear),
  .res_valid  (res_valid),
  .res_fail   (res_fail),
  .res_flips  (res_flips),
  .corr_total (corr_total),
  .fail_total (fail_total)
);

// File: tb/test_ecc_report_eval.sv
module test_ecc_report_eval;
  localparam int CLK_PERIOD = 10;
  localparam int TB_CNT_W   = 8;
  localparam int SAT        = (1 << TB_CNT_W) - 1;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                rpt_valid = 1'b0;
  logic                rpt_ready;
  logic [15:0]         rpt_word = '0;
  logic                rpt_empty = 1'b0;
  logic                cnt_clear = 1'b0;
  logic                res_valid;
  logic                res_fail;
  logic [5:0]          res_flips;
  logic [TB_CNT_W-1:0] corr_total;
  logic [TB_CNT_W-1:0] fail_total;

  int errors = 0;
  int checks = 0;
  int exp_corr = 0;
  int exp_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_report_eval #(.CNT_W(TB_CNT_W)) i_ecc_report_eval (
    .clk(clk), .rst_n(rst_n), .rpt_valid(rpt_valid), .rpt_ready(rpt_ready),
    .rpt_word(rpt_word), .rpt_empty(rpt_empty), .cnt_clear(cnt_clear),
    .res_valid(res_valid), .res_fail(res_fail), .res_flips(res_flips),
    .corr_total(corr_total), .fail_total(fail_total)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one report, sampled on the falling edge after the accepting edge
  task automatic send(input logic [15:0] w, input logic empty, input string req);
    int c0, c1, mx, sm;
    logic ok;
    c0 = int'(w[5:0]);
    c1 = int'(w[13:8]);
    ok = w[7] & w[15];
    mx = (c0 > c1) ? c0 : c1;
    sm = c0 + c1;
    rpt_word  = w;
    rpt_empty = empty;
    rpt_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rpt_valid = 1'b0;
    if (!empty) begin
      if (ok) exp_corr = (exp_corr + sm > SAT) ? SAT : exp_corr + sm;
      else    exp_fail = (exp_fail + 1 > SAT) ? SAT : exp_fail + 1;
    end
    chk({req, " R2 res_valid"}, int'(res_valid), 1);
    chk({req, " res_fail"}, int'(res_fail), (!empty && !ok) ? 1 : 0);
    chk({req, " res_flips"}, int'(res_flips), (!empty && ok) ? mx : 0);
    chk({req, " corr_total"}, int'(corr_total), exp_corr);
    chk({req, " fail_total"}, int'(fail_total), exp_fail);
  endtask

  task automatic t_reset;
    chk("R10 reset res_valid", int'(res_valid), 0);
    chk("R10 reset res_fail", int'(res_fail), 0);
    chk("R10 reset res_flips", int'(res_flips), 0);
    chk("R10 reset corr_total", int'(corr_total), 0);
    chk("R10 reset fail_total", int'(fail_total), 0);
    chk("R1 ready after reset", int'(rpt_ready), 1);
  endtask

  task automatic t_success;
    send(16'h8583, 1'b0, "R5 rest larger, R7");   // first=3 rest=5
    send(16'h8294, 1'b0, "R5 first larger, R7");  // first=20 rest=2
    send(16'hC2D4, 1'b0, "R3 spare bits set");    // same with bits 6,14
    send(16'h8787, 1'b0, "R5 equal counts");
  endtask

  task automatic t_failures;
    send(16'h8503, 1'b0, "R4 first flag low, R8");
    send(16'h0583, 1'b0, "R4 rest flag low, R8");
    send(16'h0000, 1'b0, "R4 both flags low, R8");
  endtask

  task automatic t_blank;
    send(16'h0000, 1'b1, "R6 blank failing word");
    send(16'hBFBF, 1'b1, "R6 blank counting word");
  endtask

  task automatic t_hold_and_idle;
    send(16'h8A85, 1'b0, "R2 before idle");
    @(negedge clk);
    chk("R2 no pulse when idle", int'(res_valid), 0);
    chk("R2 flips held", int'(res_flips), 10);
    chk("R2 fail held", int'(res_fail), 0);
  endtask

  task automatic t_back_to_back;
    send(16'h8101, 1'b0, "R2 back-to-back a");
    send(16'h8202, 1'b0, "R2 back-to-back b");
  endtask

  task automatic t_clear;
    cnt_clear = 1'b1;
    rpt_word  = 16'h8383;
    rpt_empty = 1'b0;
    rpt_valid = 1'b1;
    #1;
    chk("R1 ready low during clear", int'(rpt_ready), 0);
    @(posedge clk);
    @(negedge clk);
    exp_corr = 0;
    exp_fail = 0;
    chk("R10 clear corr_total", int'(corr_total), 0);
    chk("R10 clear fail_total", int'(fail_total), 0);
    chk("R1 held report not taken", int'(res_valid), 0);
    cnt_clear = 1'b0;
    #1;
    chk("R1 ready back", int'(rpt_ready), 1);
    @(posedge clk);
    @(negedge clk);
    rpt_valid = 1'b0;
    exp_corr = 6;
    chk("R1 held report taken", int'(res_valid), 1);
    chk("R7 held report counted", int'(corr_total), exp_corr);
  endtask

  task automatic t_saturate;
    for (int i = 0; i < 3; i++) send(16'hBFBF, 1'b0, "R9 corr saturation");
    chk("R9 corr at max", int'(corr_total), SAT);
    for (int i = 0; i < SAT + 3; i++) send(16'h3F3F, 1'b0, "R9 fail saturation");
    chk("R9 fail at max", int'(fail_total), SAT);
    chk("R8 corr kept at max", int'(corr_total), SAT);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_success();
    t_failures();
    t_blank();
    t_hold_and_idle();
    t_back_to_back();
    t_clear();
    t_saturate();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule